// File: doc/BRIEF.md
# Debug Entry Event Controller

This block collects every source that can stop a core for debug and decides when to raise a halt request. The sources are a halt command from the debug port, an external halt request level, breakpoint and watchpoint hit pulses, a software breakpoint commit flag, and vector catch. Vector catch watches every instruction fetch (demand fetches and prefetches alike) for an address in one of two vector tables. The security world flag of the fetch picks the table. A fetch that hits an enabled entry is remembered and turns into an event when the next instruction completes.

When an event is accepted, the block raises `halt_req_o` and records a 4-bit entry code showing which source won. The request stays up until the core acknowledges. The code stays until software clears it through a small two-register port. That port also holds the per-world vector catch enables.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After a synchronous reset, `halt_req_o`, `entry_code_o`, `entry_valid_o`, the catch enables and `reg_rdata_o` are all zero.
- R2: A halt command pulse, accepted while no halt is requested, raises `halt_req_o` at the next clock edge with entry code 0000 and `entry_valid_o` set.
- R3: A breakpoint hit gives entry code 0001, a watchpoint hit gives 0010 and a software breakpoint commit gives 0011, each raising `halt_req_o` at the next edge.
- R4: The external request is a level. It causes entry only in a cycle where `instr_done_i` is high, with code 0100. While `instr_done_i` stays low it has no effect.
- R5: A fetch with `fetch_addr_i[1:0]`=00 inside the 8-slot table at the secure base (`fetch_secure_i`=1, enable bits [7:0]) or at the non-secure base (`fetch_secure_i`=0, enable bits [15:8]) is a hit when the enable bit for slot `fetch_addr_i[4:2]` is set. The hit is held and causes entry, code 0101, at the next cycle with `instr_done_i` high. A hit in the same cycle as a completion is held for the following completion.
- R6: The enable bit is sampled at fetch time. Clearing it after a hit does not cancel the event. Setting it after a non-hitting fetch does not create one.
- R7: When several events arrive in one cycle, the code follows this priority: halt command, external request, breakpoint, software breakpoint, vector catch, watchpoint.
- R8: `halt_req_o` stays high until a cycle with `dbg_ack_i` high, and falls at the edge that closes that cycle.
- R9: While `halt_req_o` is high, new events are ignored: the entry code and valid flag do not change.
- R10: Register port: `reg_sel_i`=0 selects the 16-bit catch enable register (read/write). `reg_sel_i`=1 selects the status register, read as {halt request in bit 5, valid in bit 4, code in bits 3:0}. Writing status with bit 4 set clears the code and the valid flag. `reg_rdata_o` returns the selected register one cycle after `reg_sel_i`.
- R11: The entry code and valid flag stay after the acknowledge until software clears them. An event accepted later overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_cmd_i | input | 1 | Halt command pulse from the debug port |
| ext_halt_i | input | 1 | External halt request level |
| bkpt_hit_i | input | 1 | Breakpoint hit pulse |
| wpt_hit_i | input | 1 | Watchpoint hit pulse |
| swbk_commit_i | input | 1 | Software breakpoint instruction committed |
| instr_done_i | input | 1 | Instruction completion strobe |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_addr_i | input | AW | Fetch address |
| fetch_secure_i | input | 1 | Fetch world: 1 secure, 0 non-secure |
| dbg_ack_i | input | 1 | Core acknowledges debug entry |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 catch enables, 1 status |
| reg_wdata_i | input | 2*NVEC | Register write data |
| reg_rdata_o | output | 2*NVEC | Registered read data |
| halt_req_o | output | 1 | Halt request to the core |
| entry_code_o | output | 4 | Method-of-entry code |
| entry_valid_o | output | 1 | Entry code holds a recorded entry |

## Verification
Two pairs of functions can meet in one cycle. A vector catch fetch can coincide with the completion that releases an earlier held hit. A software clear of the status register can land on the same edge as a newly accepted event. Directed cases drive each pair deliberately: fetch and completion together, then a clear written together with a watchpoint pulse. Seeded random traffic then keeps all sources, completions, acknowledges and register writes overlapping freely. Every cycle, the outputs are compared with a bench model. That model applies the priority order, the hold-until-completion rule for vector hits and the rule that acceptance beats clear.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam logic [3:0] MOE_HALT   = 4'b0000;
  localparam logic [3:0] MOE_BKPT   = 4'b0001;
  localparam logic [3:0] MOE_WATCH  = 4'b0010;
  localparam logic [3:0] MOE_SWBK   = 4'b0011;
  localparam logic [3:0] MOE_EXT    = 4'b0100;
  localparam logic [3:0] MOE_VCATCH = 4'b0101;

  // one flag per source, listed from highest to lowest priority
  typedef struct packed {
    logic halt_cmd;
    logic ext;
    logic bkpt;
    logic swbk;
    logic vcatch;
    logic watch;
  } evt_t;
endpackage

// File: rtl/vec_catch_unit.sv
module vec_catch_unit #(
  parameter int              AW      = 32,
  parameter int              NVEC    = 8,
  parameter logic [AW-1:0]   SEC_BASE = '0,
  parameter logic [AW-1:0]   NS_BASE  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              fetch_secure_i,
  input  logic [2*NVEC-1:0] catch_en_i,
  input  logic              instr_done_i,
  output logic              vc_evt_o
);
  localparam int IW  = $clog2(NVEC);
  localparam int LOW = IW + 2;
  localparam logic [AW-LOW-1:0] SEC_TAG = SEC_BASE[AW-1:LOW];
  localparam logic [AW-LOW-1:0] NS_TAG  = NS_BASE[AW-1:LOW];

  logic [NVEC-1:0] sec_en, ns_en;
  logic [IW-1:0]   slot;
  logic            in_table, slot_en, hit, held;

  assign sec_en   = catch_en_i[NVEC-1:0];
  assign ns_en    = catch_en_i[2*NVEC-1:NVEC];
  assign slot     = fetch_addr_i[LOW-1:2];
  assign in_table = (fetch_addr_i[1:0] == 2'b00) &&
                    (fetch_addr_i[AW-1:LOW] == (fetch_secure_i ? SEC_TAG : NS_TAG));
  assign slot_en  = fetch_secure_i ? sec_en[slot] : ns_en[slot];
  assign hit      = fetch_valid_i && in_table && slot_en;

  // enable is sampled here, at fetch time; the event waits for completion
  always_ff @(posedge clk) begin
    if (rst)               held <= 1'b0;
    else if (hit)          held <= 1'b1;
    else if (instr_done_i) held <= 1'b0;
  end

  assign vc_evt_o = held && instr_done_i;

  AST_VC_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(fetch_valid_i));  // R5
endmodule

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import dbg_entry_pkg::*;
(
  input  evt_t       evt_i,
  output logic       any_o,
  output logic [3:0] code_o
);
  assign any_o = |evt_i;

  always_comb begin
    if (evt_i.halt_cmd)    code_o = MOE_HALT;
    else if (evt_i.ext)    code_o = MOE_EXT;
    else if (evt_i.bkpt)   code_o = MOE_BKPT;
    else if (evt_i.swbk)   code_o = MOE_SWBK;
    else if (evt_i.vcatch) code_o = MOE_VCATCH;
    else                   code_o = MOE_WATCH;
  end
endmodule

// File: rtl/entry_status_regs.sv
module entry_status_regs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_any_i,
  input  logic [3:0]    evt_code_i,
  input  logic          dbg_ack_i,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [CW-1:0] reg_wdata_i,
  output logic [CW-1:0] reg_rdata_o,
  output logic [CW-1:0] catch_en_o,
  output logic          halt_req_o,
  output logic [3:0]    code_o,
  output logic          valid_o
);
  localparam int CLR_BIT = 4;

  logic accept, clear_wr;
  assign accept   = evt_any_i && !halt_req_o;
  assign clear_wr = reg_wr_i && reg_sel_i && reg_wdata_i[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      catch_en_o  <= '0;
      halt_req_o  <= 1'b0;
      code_o      <= 4'b0000;
      valid_o     <= 1'b0;
      reg_rdata_o <= '0;
    end else begin
      if (reg_wr_i && !reg_sel_i) catch_en_o <= reg_wdata_i;

      if (accept)                     halt_req_o <= 1'b1;
      else if (halt_req_o && dbg_ack_i) halt_req_o <= 1'b0;

      // a new entry wins over a clear landing on the same edge
      if (accept) begin
        code_o  <= evt_code_i;
        valid_o <= 1'b1;
      end else if (clear_wr) begin
        code_o  <= 4'b0000;
        valid_o <= 1'b0;
      end

      reg_rdata_o <= reg_sel_i ? {{(CW-6){1'b0}}, halt_req_o, valid_o, code_o}
                               : catch_en_o;
    end
  end

  AST_HALT_HELD: assert property (@(posedge clk) disable iff (rst)
    halt_req_o && !dbg_ack_i |=> halt_req_o);  // R8
  AST_ACCEPT_RECORDS: assert property (@(posedge clk) disable iff (rst)
    !halt_req_o && evt_any_i |=> halt_req_o && valid_o);  // R2
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halt_req_o && !clear_wr |=> $stable(code_o) && $stable(valid_o));  // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    halt_req_o && clear_wr |=> !valid_o && code_o == 4'b0000);  // R10
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            NVEC      = 8,
  parameter logic [AW-1:0] SEC_VBASE = 32'h0000_0000,
  parameter logic [AW-1:0] NS_VBASE  = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_cmd_i,
  input  logic              ext_halt_i,
  input  logic              bkpt_hit_i,
  input  logic              wpt_hit_i,
  input  logic              swbk_commit_i,
  input  logic              instr_done_i,
  input  logic              fetch_valid_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              fetch_secure_i,
  input  logic              dbg_ack_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [2*NVEC-1:0] reg_wdata_i,
  output logic [2*NVEC-1:0] reg_rdata_o,
  output logic              halt_req_o,
  output logic [3:0]        entry_code_o,
  output logic              entry_valid_o
);
  localparam int CW = 2 * NVEC;

  logic [CW-1:0] catch_en;
  logic          vc_evt, evt_any;
  logic [3:0]    evt_code;
  evt_t          evt;

  vec_catch_unit #(
    .AW(AW), .NVEC(NVEC), .SEC_BASE(SEC_VBASE), .NS_BASE(NS_VBASE)
  ) i_vc (
    .clk(clk), .rst(rst),
    .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
    .fetch_secure_i(fetch_secure_i), .catch_en_i(catch_en),
    .instr_done_i(instr_done_i), .vc_evt_o(vc_evt)
  );

  always_comb begin
    evt.halt_cmd = halt_cmd_i;
    evt.ext      = ext_halt_i && instr_done_i;  // only at an instruction boundary
    evt.bkpt     = bkpt_hit_i;
    evt.swbk     = swbk_commit_i;
    evt.vcatch   = vc_evt;
    evt.watch    = wpt_hit_i;
  end

  entry_arbiter i_arb (.evt_i(evt), .any_o(evt_any), .code_o(evt_code));

  entry_status_regs #(.CW(CW)) i_regs (
    .clk(clk), .rst(rst),
    .evt_any_i(evt_any), .evt_code_i(evt_code), .dbg_ack_i(dbg_ack_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .catch_en_o(catch_en),
    .halt_req_o(halt_req_o), .code_o(entry_code_o), .valid_o(entry_valid_o)
  );

  AST_EXT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req_o) && entry_code_o == MOE_EXT |-> $past(ext_halt_i && instr_done_i));  // R4
  AST_VC_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req_o) && entry_code_o == MOE_VCATCH |-> $past(instr_done_i));  // R5
  AST_HALT_CMD_TOP: assert property (@(posedge clk) disable iff (rst)
    !halt_req_o && halt_cmd_i |=> entry_code_o == MOE_HALT);  // R7
endmodule

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
  localparam logic [31:0] SB = 32'h0000_0000;
  localparam logic [31:0] NB = 32'hFFFF_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic halt_cmd = 0, ext = 0, bp = 0, wp = 0, swbk = 0, done = 0;
  logic fv = 0, sec = 0, ack = 0, wr = 0, sel = 0;
  logic [31:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        halt_req_o, valid_o;
  logic [3:0]  code_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbg_entry_ctrl i_dbg_entry_ctrl (
    .clk(clk), .rst(rst), .halt_cmd_i(halt_cmd), .ext_halt_i(ext),
    .bkpt_hit_i(bp), .wpt_hit_i(wp), .swbk_commit_i(swbk), .instr_done_i(done),
    .fetch_valid_i(fv), .fetch_addr_i(addr), .fetch_secure_i(sec),
    .dbg_ack_i(ack), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .halt_req_o(halt_req_o), .entry_code_o(code_o),
    .entry_valid_o(valid_o)
  );

  // reference model, built from the requirements
  logic m_halt, m_valid, m_hold;
  logic [3:0] m_code;
  logic [15:0] m_en, m_rdata;

  function automatic logic vec_hit(logic v, logic [31:0] a, logic s, logic [15:0] en);
    logic [31:0] base = s ? SB : NB;
    logic [2:0]  k = a[4:2];
    if (!v || a[1:0] != 2'b00 || a[31:5] != base[31:5]) return 1'b0;
    return s ? en[k] : en[8 + k];
  endfunction

  function automatic logic [4:0] pick(logic h, logic e, logic b, logic s, logic v, logic w);
    if (h) return 5'b1_0000;
    if (e) return 5'b1_0100;
    if (b) return 5'b1_0001;
    if (s) return 5'b1_0011;
    if (v) return 5'b1_0101;
    if (w) return 5'b1_0010;
    return 5'b0_0000;
  endfunction

  always @(posedge clk) begin
    logic [4:0] p;
    if (rst) begin
      m_halt <= 0; m_valid <= 0; m_hold <= 0; m_code <= 0; m_en <= 0; m_rdata <= 0;
    end else begin
      p = pick(halt_cmd, ext && done, bp, swbk, m_hold && done, wp);
      m_hold  <= vec_hit(fv, addr, sec, m_en) ? 1'b1 : (done ? 1'b0 : m_hold);
      m_rdata <= sel ? {10'b0, m_halt, m_valid, m_code} : m_en;
      if (wr && !sel) m_en <= wdata;
      if (p[4] && !m_halt) m_halt <= 1'b1;
      else if (m_halt && ack) m_halt <= 1'b0;
      if (p[4] && !m_halt) begin m_code <= p[3:0]; m_valid <= 1'b1; end
      else if (wr && sel && wdata[4]) begin m_code <= 0; m_valid <= 0; end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R8 model halt_req", {31'b0, halt_req_o}, {31'b0, m_halt});
    chk("R7 model entry_code", {28'b0, code_o}, {28'b0, m_code});
    chk("R11 model entry_valid", {31'b0, valid_o}, {31'b0, m_valid});
    chk("R10 model rdata", {16'b0, rdata}, {16'b0, m_rdata});
  endtask

  task automatic idle();
    halt_cmd = 0; bp = 0; wp = 0; swbk = 0; done = 0; fv = 0;
    ack = 0; wr = 0; sel = 0; wdata = '0;
  endtask

  task automatic ack_and_clear();
    idle(); ack = 1; tick();
    idle(); wr = 1; sel = 1; wdata = 16'h0010; tick();
    idle();
  endtask

  task automatic write_en(logic [15:0] v);
    idle(); wr = 1; sel = 0; wdata = v; tick(); idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog got %0d exp below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rst = 1; tick(); tick();
    rst = 0;
    // R1 reset values
    chk("R1 halt_req", {31'b0, halt_req_o}, 0);
    chk("R1 entry_code", {28'b0, code_o}, 0);
    chk("R1 valid", {31'b0, valid_o}, 0);
    chk("R1 rdata", {16'b0, rdata}, 0);

    // R2 halt command
    halt_cmd = 1; tick(); idle();
    chk("R2 halt_req", {31'b0, halt_req_o}, 1);
    chk("R2 code", {28'b0, code_o}, 4'b0000);
    chk("R2 valid", {31'b0, valid_o}, 1);
    tick();
    chk("R8 held w/o ack", {31'b0, halt_req_o}, 1);
    ack = 1; tick(); idle();
    chk("R8 drop on ack", {31'b0, halt_req_o}, 0);
    chk("R11 valid kept", {31'b0, valid_o}, 1);
    sel = 1; tick(); idle();
    chk("R10 status read", {16'b0, rdata}, 32'h10);
    wr = 1; sel = 1; wdata = 16'h0010; tick(); idle();
    chk("R10 clear", {31'b0, valid_o}, 0);

    // R4 external request level, waits for completion
    ext = 1; tick(); tick(); tick();
    chk("R4 no entry w/o done", {31'b0, halt_req_o}, 0);
    done = 1; tick(); idle(); ext = 0;
    chk("R4 entry at done", {31'b0, halt_req_o}, 1);
    chk("R4 code", {28'b0, code_o}, 4'b0100);
    ack_and_clear();

    // R3 single sources
    bp = 1; tick(); chk("R3 bkpt code", {28'b0, code_o}, 4'b0001); ack_and_clear();
    wp = 1; tick(); chk("R3 watch code", {28'b0, code_o}, 4'b0010); ack_and_clear();
    swbk = 1; tick(); chk("R3 swbk code", {28'b0, code_o}, 4'b0011); ack_and_clear();

    // R5 vector catch, secure slot 3 and non-secure slot 1
    write_en(16'h0208);
    sel = 0; tick(); idle();
    chk("R10 enable read", {16'b0, rdata}, 32'h0208);
    fv = 1; sec = 1; addr = SB + 32'd12; tick(); idle();
    chk("R5 not before done", {31'b0, halt_req_o}, 0);
    done = 1; tick(); idle();
    chk("R5 secure catch", {28'b0, code_o}, 4'b0101);
    ack_and_clear();
    // hit together with a completion is kept for the next completion
    fv = 1; sec = 0; addr = NB + 32'd4; done = 1; tick(); idle();
    chk("R5 same-cycle done no entry", {31'b0, halt_req_o}, 0);
    done = 1; tick(); idle();
    chk("R5 non-secure catch", {28'b0, code_o}, 4'b0101);
    ack_and_clear();
    fv = 1; sec = 1; addr = NB + 32'd4; tick(); idle();
    done = 1; tick(); idle();
    chk("R5 wrong world ignored", {31'b0, halt_req_o}, 0);
    fv = 1; sec = 0; addr = NB + 32'd8; tick(); idle();
    done = 1; tick(); idle();
    chk("R5 disabled slot ignored", {31'b0, halt_req_o}, 0);

    // R6 enable sampled at fetch
    write_en(16'h0008);
    fv = 1; sec = 1; addr = SB + 32'd12; tick(); idle();
    write_en(16'h0000);
    done = 1; tick(); idle();
    chk("R6 disable after hit", {31'b0, halt_req_o}, 1);
    ack_and_clear();
    fv = 1; sec = 1; addr = SB + 32'd12; tick(); idle();
    write_en(16'h0008);
    done = 1; tick(); idle();
    chk("R6 enable after fetch", {31'b0, halt_req_o}, 0);

    // R7 priority
    halt_cmd = 1; ext = 1; done = 1; bp = 1; tick(); idle(); ext = 0;
    chk("R7 halt first", {28'b0, code_o}, 4'b0000); ack_and_clear();
    ext = 1; done = 1; bp = 1; swbk = 1; tick(); idle(); ext = 0;
    chk("R7 ext over bkpt", {28'b0, code_o}, 4'b0100); ack_and_clear();
    bp = 1; swbk = 1; wp = 1; tick(); idle();
    chk("R7 bkpt over swbk", {28'b0, code_o}, 4'b0001); ack_and_clear();
    fv = 1; sec = 1; addr = SB + 32'd12; tick(); idle();
    done = 1; swbk = 1; wp = 1; tick(); idle();
    chk("R7 swbk over vcatch", {28'b0, code_o}, 4'b0011); ack_and_clear();
    fv = 1; sec = 1; addr = SB + 32'd12; tick(); idle();
    done = 1; wp = 1; tick(); idle();
    chk("R7 vcatch over watch", {28'b0, code_o}, 4'b0101);

    // R9 events ignored while halted
    wp = 1; bp = 1; tick(); idle();
    chk("R9 code unchanged", {28'b0, code_o}, 4'b0101);
    chk("R9 valid unchanged", {31'b0, valid_o}, 1);
    ack = 1; tick(); idle();
    // R11 new entry overwrites without a clear; entry beats clear
    wp = 1; wr = 1; sel = 1; wdata = 16'h0010; tick(); idle();
    chk("R11 overwrite", {28'b0, code_o}, 4'b0010);
    chk("R11 entry beats clear", {31'b0, valid_o}, 1);
    ack = 1; tick(); idle();

    // seeded random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      halt_cmd = ($urandom % 24) == 0;
      bp       = ($urandom % 10) == 0;
      wp       = ($urandom % 10) == 0;
      swbk     = ($urandom % 12) == 0;
      if (($urandom % 8) == 0) ext = ~ext;
      done     = ($urandom % 2) == 0;
      fv       = ($urandom % 2) == 0;
      sec      = $urandom % 2;
      case ($urandom % 3)
        0: addr = SB + ($urandom % 32);
        1: addr = NB + ($urandom % 32);
        default: addr = $urandom;
      endcase
      ack      = m_halt && (($urandom % 3) == 0);
      wr       = ($urandom % 10) == 0;
      sel      = $urandom % 2;
      wdata    = $urandom;
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule